// File: doc/BRIEF.md
# Sector Storage Command Master

This block turns a single sector transfer request into the register sequence an external block-storage controller expects, then paces the sector data that the controller moves. A request carries a logical block address, a sector count and a direction. The block adds a configured base offset to the address. It writes the resulting sector address, the count and a command code to the controller through a memory-mapped master port. Each of these writes is held until the controller stops stalling it.

After the command word is accepted, the controller moves the data through the block's slave port, one 32-bit word per strobe. On a storage read, the controller writes each word into the slave, and the block forwards it to a sector buffer together with its running word index. On a storage write, the controller reads the slave. The block fetches the word at the current index from the buffer and presents it on the slave's read data one cycle after the strobe. When 128 words per requested sector have passed, the block pulses `done` and accepts the next request.

Top module: `sector_cmd_master`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0, `m_write` is 0 and `buf_we` is 0.
- R2: The first master write of a request targets address 0x4, and its data is `req_lba + base_offset`.
- R3: The second master write targets address 0x8, and its data is the requested count, zero-extended.
- R4: The third and last master write targets address 0xC. Its data is 2 for a storage read (`req_write`=0) and 3 for a storage write (`req_write`=1). No master write happens at any other time.
- R5: While `m_waitrequest` is 1, a pending master write stays asserted, with address and data unchanged.
- R6: During a storage read, each `s_write` strobe produces `buf_we`=1 in the next cycle. That cycle carries `buf_wdata` equal to the strobed `s_writedata` and `buf_waddr` equal to the word's index, counted from 0 from the start of the request.
- R7: During a storage write, `s_readdata` holds, from the cycle after an `s_read` strobe, the `buf_rdata` value for the index of that word, counted from 0.
- R8: `done` is 0 until 128 × count words have been strobed. It is 1 for exactly the one cycle after the last strobe, after which `req_ready` is 1.
- R9: A `req_valid` raised while `req_ready` is 0 is ignored: no extra master write or transfer follows.
- R10: Slave strobes outside the data phase of a request are ignored: no `buf_we` pulse results and `s_readdata` is not changed.
- R11: A request with a count of 0 issues all three master writes, then pulses `done` in the cycle after the command write is accepted, with no data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_offset | input | 32 | Sector offset added to every requested address |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_lba | input | 32 | Logical block address of the first sector |
| req_count | input | CNT_W | Number of sectors |
| req_write | input | 1 | 1 = storage write, 0 = storage read |
| req_ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| m_address | output | 32 | Master register address |
| m_write | output | 1 | Master write strobe |
| m_writedata | output | 32 | Master write data |
| m_waitrequest | input | 1 | Controller stall for the master write |
| s_write | input | 1 | Controller delivers a read word |
| s_writedata | input | 32 | Word delivered by the controller |
| s_read | input | 1 | Controller fetches a write word |
| s_readdata | output | 32 | Word supplied to the controller |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | CNT_W+7 | Buffer write word index |
| buf_wdata | output | 32 | Buffer write word |
| buf_raddr | output | CNT_W+7 | Buffer read word index |
| buf_rdata | input | 32 | Buffer word at `buf_raddr` |

## Verification
A wrong sequencer state appears at the ports within one accepted master write. The write shows a wrong address, comes in the wrong order, appears while idle, or a stalled write drops or changes. A wrong word index shows on the first data beat after the error, as a mismatched `buf_waddr` or `s_readdata`. A wrong word total shows only at the end of the request, as a `done` pulse one or more beats early or late. Strobes raised while idle expose at once any data path that is not gated by the data phase.

// File: rtl/sector_cmd_master.sv
module sector_cmd_master #(
  parameter int CNT_W        = 16,
  parameter int SECTOR_WORDS = 128,
  parameter logic [31:0] REG_LBA = 32'h4,
  parameter logic [31:0] REG_CNT = 32'h8,
  parameter logic [31:0] REG_CMD = 32'hC,
  parameter logic [31:0] CODE_RD = 32'd2,
  parameter logic [31:0] CODE_WR = 32'd3,
  localparam int SW = $clog2(SECTOR_WORDS),
  localparam int IW = CNT_W + SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      base_offset,
  input  logic             req_valid,
  input  logic [31:0]      req_lba,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_write,
  output logic             req_ready,
  output logic             done,
  output logic [31:0]      m_address,
  output logic             m_write,
  output logic [31:0]      m_writedata,
  input  logic             m_waitrequest,
  input  logic             s_write,
  input  logic [31:0]      s_writedata,
  input  logic             s_read,
  output logic [31:0]      s_readdata,
  output logic             buf_we,
  output logic [IW-1:0]    buf_waddr,
  output logic [31:0]      buf_wdata,
  output logic [IW-1:0]    buf_raddr,
  input  logic [31:0]      buf_rdata
);

  typedef enum logic [2:0] {IDLE, WLBA, WCNT, WCMD, XFER, FIN} st_t;

  st_t              st;
  logic [31:0]      sec_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic [IW-1:0]    idx;

  wire [IW-1:0] total = {cnt_q, {SW{1'b0}}};
  wire          take  = dir_q ? s_read : s_write;
  wire          beat  = (st == XFER) && take;
  wire          last  = beat && (idx == total - 1'b1);

  assign req_ready = (st == IDLE);
  assign done      = (st == FIN);
  assign m_write   = (st == WLBA) || (st == WCNT) || (st == WCMD);
  assign buf_raddr = idx;

  always_comb begin
    case (st)
      WLBA:    begin m_address = REG_LBA; m_writedata = sec_q; end
      WCNT:    begin m_address = REG_CNT; m_writedata = 32'(cnt_q); end
      WCMD:    begin m_address = REG_CMD; m_writedata = dir_q ? CODE_WR : CODE_RD; end
      default: begin m_address = '0;      m_writedata = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      sec_q      <= '0;
      cnt_q      <= '0;
      dir_q      <= 1'b0;
      idx        <= '0;
      buf_we     <= 1'b0;
      buf_waddr  <= '0;
      buf_wdata  <= '0;
      s_readdata <= '0;
    end else begin
      buf_we <= beat && !dir_q;
      if (beat && !dir_q) begin
        buf_waddr <= idx;
        buf_wdata <= s_writedata;
      end
      if (beat && dir_q) s_readdata <= buf_rdata;
      case (st)
        IDLE: if (req_valid) begin
          sec_q <= req_lba + base_offset;
          cnt_q <= req_count;
          dir_q <= req_write;
          st    <= WLBA;
        end
        WLBA: if (!m_waitrequest) st <= WCNT;
        WCNT: if (!m_waitrequest) st <= WCMD;
        WCMD: if (!m_waitrequest) begin
          idx <= '0;
          st  <= (cnt_q == '0) ? FIN : XFER;
        end
        XFER: begin
          if (beat) idx <= idx + 1'b1;
          if (last) st <= FIN;
        end
        FIN:     st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_write && m_waitrequest |=> m_write && $stable(m_address) && $stable(m_writedata));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !m_write);

  assert_buf_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(s_write) && !$past(req_ready));

  assert_cmd_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_write && (m_address == REG_CMD) |-> (m_writedata == CODE_RD) || (m_writedata == CODE_WR));

endmodule

// File: tb/test_sector_cmd_master.sv
module test_sector_cmd_master;
  localparam int CNT_W = 16;
  localparam int IW = CNT_W + 7;
  localparam logic [31:0] BASE = 32'h0001_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_lba = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic req_ready, done;
  logic [31:0] m_address, m_writedata;
  logic m_write;
  logic m_waitrequest = 1'b0;
  logic s_write = 1'b0, s_read = 1'b0;
  logic [31:0] s_writedata = '0;
  logic [31:0] s_readdata;
  logic buf_we;
  logic [IW-1:0] buf_waddr, buf_raddr;
  logic [31:0] buf_wdata, buf_rdata;

  int n_cmp = 0, n_bad = 0;
  bit stall_en = 1'b0;
  logic [63:0] mq[$];
  logic [63:0] bq[$];
  bit prev_stall = 1'b0;
  logic [63:0] prev_mw = '0;

  always #4 clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 ^ (32'(i) * 32'd7);
  endfunction

  assign buf_rdata = pat(int'(buf_raddr));

  sector_cmd_master #(.CNT_W(CNT_W)) i_sector_cmd_master (
    .clk(clk), .rst_n(rst_n), .base_offset(BASE),
    .req_valid(req_valid), .req_lba(req_lba), .req_count(req_count), .req_write(req_write),
    .req_ready(req_ready), .done(done),
    .m_address(m_address), .m_write(m_write), .m_writedata(m_writedata), .m_waitrequest(m_waitrequest),
    .s_write(s_write), .s_writedata(s_writedata), .s_read(s_read), .s_readdata(s_readdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      m_waitrequest = stall_en && (c % 3 != 2);
      c++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (m_write) begin
      if (prev_stall) chk({m_address, m_writedata} == prev_mw, "R5 stalled write changed", {m_address, m_writedata}, prev_mw);
      prev_stall = m_waitrequest;
      prev_mw = {m_address, m_writedata};
      if (!m_waitrequest) begin
        if (mq.size() == 0) chk(1'b0, "R9 unexpected master write", {m_address, m_writedata}, 64'd0);
        else begin
          logic [63:0] e;
          e = mq.pop_front();
          chk({m_address, m_writedata} == e, "R2 R3 R4 master write", {m_address, m_writedata}, e);
        end
      end
    end else begin
      if (prev_stall) chk(1'b0, "R5 stalled write dropped", 64'd0, prev_mw);
      prev_stall = 1'b0;
    end
    if (buf_we) begin
      if (bq.size() == 0) chk(1'b0, "R10 unexpected buffer write", {32'(buf_waddr), buf_wdata}, 64'd0);
      else begin
        logic [63:0] e;
        e = bq.pop_front();
        chk({32'(buf_waddr), buf_wdata} == e, "R6 buffer write", {32'(buf_waddr), buf_wdata}, e);
      end
    end
  end

  task automatic issue(input logic [31:0] lba, input int cnt, input bit wr);
    while (!req_ready) begin @(posedge clk); #1; end
    mq.push_back({32'h4, lba + BASE});
    mq.push_back({32'h8, 32'(cnt)});
    mq.push_back({32'hC, wr ? 32'd3 : 32'd2});
    req_valid = 1'b1; req_lba = lba; req_count = CNT_W'(cnt); req_write = wr;
    @(posedge clk); #1;
    req_lba = 32'hDEAD_0000; req_count = 5; req_write = ~wr;
    @(posedge clk); #1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    while (mq.size() != 0) begin @(posedge clk); #1; end
  endtask

  task automatic end_check(input string tag);
    chk(done == 1'b1, {tag, " done after last word"}, 64'(done), 64'd1);
    @(posedge clk); #1;
    chk(done == 1'b0 && req_ready == 1'b1, {tag, " done single, ready back"}, {done, req_ready}, 2'b01);
  endtask

  task automatic stream_read(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = 32'h3C00_0000 + 32'(i) * 32'd13;
      bq.push_back({32'(i), d});
      if (i == n - 1) chk(done == 1'b0, "R8 done not early", 64'(done), 64'd0);
      s_write = 1'b1; s_writedata = d;
      @(posedge clk); #1;
      s_write = 1'b0;
      if (gaps && (i % 5 == 1) && i != n - 1) begin @(posedge clk); #1; end
    end
    end_check("R8");
    chk(bq.size() == 0, "R6 all words forwarded", 64'(bq.size()), 64'd0);
  endtask

  task automatic stream_write(input int n);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) chk(done == 1'b0, "R8 done not early", 64'(done), 64'd0);
      s_read = 1'b1;
      @(posedge clk); #1;
      s_read = 1'b0;
      chk(s_readdata == pat(i), "R7 supplied word", 64'(s_readdata), 64'(pat(i)));
      if (i % 7 == 3 && i != n - 1) begin @(posedge clk); #1; end
    end
    end_check("R8");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !m_write && !buf_we, "R1 reset state",
        {req_ready, done, m_write, buf_we}, 4'b1000);
    @(posedge clk); #1;

    s_write = 1'b1; s_writedata = 32'hFFFF_FFFF; s_read = 1'b1;
    @(posedge clk); #1;
    s_write = 1'b0; s_read = 1'b0;
    @(posedge clk); #1;
    chk(s_readdata == 32'd0, "R10 idle read strobe ignored", 64'(s_readdata), 64'd0);
    chk(req_ready == 1'b1, "R10 idle strobes keep ready", 64'(req_ready), 64'd1);

    stall_en = 1'b1;
    issue(32'h0000_0020, 1, 1'b0);
    stall_en = 1'b0;
    stream_read(128, 1'b1);

    issue(32'h0000_1000, 2, 1'b1);
    stream_write(256);

    stall_en = 1'b1;
    issue(32'h0000_0077, 0, 1'b1);
    stall_en = 1'b0;
    chk(done == 1'b1, "R11 zero count done", 64'(done), 64'd1);
    @(posedge clk); #1;
    chk(done == 1'b0 && req_ready, "R11 zero count back to idle", {done, req_ready}, 2'b01);

    issue(32'hFFFF_FFF0, 2, 1'b0);
    stream_read(256, 1'b0);

    s_write = 1'b1; s_read = 1'b1;
    @(posedge clk); #1;
    s_write = 1'b0; s_read = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(mq.size() == 0 && bq.size() == 0, "R9 no stray activity", 64'(mq.size() + bq.size()), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R8 watchdog expired act=0 exp=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule